// File: doc/BRIEF.md
# Sidetone Coefficient Register Block

This block is the memory-mapped front end of an audio sidetone filter core. A 32-bit register bus (address, write strobe, write data, combinational read data) reaches a small register map: a fixed identification word, a configuration word with a clock auto-idle bit, a one-bit interrupt status and enable pair, a packed two-channel signed gain word, a coefficient port and a control word. The held register contents drive the filter datapath directly: an enable, two 16-bit gains, the auto-idle level and the filter taps.

The filter taps are never addressed one by one. Software arms a load by setting the coefficient write enable in the control word. It then writes 128 values to the single coefficient port, and each write takes the next tap in order starting at tap 0. A load engine tracks the fill. It has three states: `LD_IDLE` (not armed), `LD_FILL` (armed, taps still open) and `LD_FULL` (all taps written). Every transition is named here. `ARM` is a 0-to-1 change of the write enable and goes from any state to `LD_FILL`. `DISARM` is a 1-to-0 change and goes from `LD_FILL` or `LD_FULL` to `LD_IDLE`. `LAST_TAP` is the port write that stores the final tap and goes from `LD_FILL` to `LD_FULL`. The done flag is set on `LAST_TAP` and cleared only on `ARM`, so software can poll it, clear the enable and still read it.

Top module: `st_coef_regif`

## Requirements
- R1: After reset the configuration word reads 1 (auto-idle on). The control, gain and interrupt words read 0, `st_en_o` and `irq_o` are 0, and `auto_idle_o` is 1.
- R2: Offset 0x00 always reads the parameter `REV_ID`, and writes to it have no effect. The coefficient port (0x28) reads 0, and every unmapped offset reads 0.
- R3: The gain word at 0x24 holds the channel 0 gain in bits 15:0 and the channel 1 gain in bits 31:16. It reads back as written and drives `gain0_o` and `gain1_o`, which change only when 0x24 is written.
- R4: In the control word at 0x2C, bit 0 is the sidetone enable and drives `st_en_o`, bit 1 is the coefficient write enable, and bit 2 is the done flag. Bit 2 is read-only, and writing 1 to it does not set it.
- R5: Bit 0 of the configuration word at 0x10 is read/write and drives `auto_idle_o`.
- R6: A 0-to-1 change of control bit 1 clears the done flag and restarts the fill at tap 0. While armed, each write to 0x28 stores its bits 15:0 into the next tap in ascending order.
- R7: The done flag stays 0 after 127 port writes of a load and reads 1 right after the 128th.
- R8: A port write while control bit 1 is 0, or after all 128 taps of the load are stored, changes no tap and does not move the fill position.
- R9: Clearing control bit 1 leaves the done flag readable as 1. Clearing bit 1 and setting it again, mid-load or after a load, clears the done flag and makes the next port write land in tap 0.
- R10: Bit 0 of the interrupt status word (0x18) is set on the cycle the done flag sets and is cleared by writing 1 to it. `irq_o` is status bit 0 AND bit 0 of the interrupt enable word (0x1C).
- R11: `tap_coef_o` returns the stored coefficient of the tap selected by `tap_idx_i`, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| tap_idx_i | input | IDX_W | Tap number for the coefficient read port |
| tap_coef_o | output | COEF_W | Stored coefficient of `tap_idx_i` |
| gain0_o | output | COEF_W | Channel 0 gain |
| gain1_o | output | COEF_W | Channel 1 gain |
| st_en_o | output | 1 | Sidetone enable |
| auto_idle_o | output | 1 | Clock auto-idle control |
| irq_o | output | 1 | Load-complete interrupt |

## Verification
The bench checks the done flag at the 127/128 boundary. A pointer that is off by one would raise the flag one write early, or never raise it. It writes extra port values after a full load and with the enable cleared, then reads taps 0 and 127. A design that kept counting or wrapped would overwrite them. It also runs a clear-then-set mid-load and after a completed load, and then checks that tap 0 holds the first value of the new load and that the done flag reads 0. It checks that the done flag survives the enable being cleared, since a design that tied done to the enable would lose it before software could read it.

// File: rtl/st_pkg.sv
package st_pkg;
    localparam int OFF_REV   = 'h00;
    localparam int OFF_CFG   = 'h10;
    localparam int OFF_IRQST = 'h18;
    localparam int OFF_IRQEN = 'h1C;
    localparam int OFF_GAIN  = 'h24;
    localparam int OFF_PORT  = 'h28;
    localparam int OFF_CTRL  = 'h2C;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_WREN_BIT = 1;
    localparam int CTRL_DONE_BIT = 2;

    typedef enum logic [1:0] {
        LD_IDLE = 2'd0,
        LD_FILL = 2'd1,
        LD_FULL = 2'd2
    } ld_state_t;
endpackage

// File: rtl/st_load_fsm.sv
module st_load_fsm
    import st_pkg::*;
#(
    parameter int NTAPS = 128,
    parameter int IDX_W = $clog2(NTAPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             disarm,
    input  logic             port_wr,
    output logic             ram_we,
    output logic [IDX_W-1:0] ptr,
    output logic             done,
    output logic             done_set
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NTAPS - 1);

    ld_state_t state, state_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LD_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        if (arm) begin
            state_nx = LD_FILL;
        end else begin
            unique case (state)
                LD_IDLE: state_nx = LD_IDLE;
                LD_FILL: begin
                    if (disarm)                      state_nx = LD_IDLE;
                    else if (port_wr && ptr == LAST) state_nx = LD_FULL;
                end
                LD_FULL: if (disarm) state_nx = LD_IDLE;
                default: state_nx = LD_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        ram_we   = (state == LD_FILL) && port_wr && !arm;
        done_set = ram_we && (ptr == LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr  <= '0;
            done <= 1'b0;
        end else if (arm) begin
            ptr  <= '0;
            done <= 1'b0;
        end else begin
            if (ram_we && ptr != LAST) ptr <= ptr + 1'b1;
            if (done_set)              done <= 1'b1;
        end
    end
endmodule

// File: rtl/st_coef_ram.sv
module st_coef_ram #(
    parameter int NTAPS  = 128,
    parameter int COEF_W = 16,
    parameter int IDX_W  = $clog2(NTAPS)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [COEF_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [COEF_W-1:0] rdata
);
    logic [COEF_W-1:0] mem [NTAPS];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/st_coef_regif.sv
module st_coef_regif
    import st_pkg::*;
#(
    parameter int          ADDR_W = 8,
    parameter int          DATA_W = 32,
    parameter int          COEF_W = 16,
    parameter int          NTAPS  = 128,
    parameter logic [31:0] REV_ID = 32'h0000_0103,
    parameter int          IDX_W  = $clog2(NTAPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [IDX_W-1:0]  tap_idx_i,
    output logic [COEF_W-1:0] tap_coef_o,
    output logic [COEF_W-1:0] gain0_o,
    output logic [COEF_W-1:0] gain1_o,
    output logic              st_en_o,
    output logic              auto_idle_o,
    output logic              irq_o
);
    localparam logic [ADDR_W-1:0] A_REV   = ADDR_W'(OFF_REV);
    localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(OFF_CFG);
    localparam logic [ADDR_W-1:0] A_IRQST = ADDR_W'(OFF_IRQST);
    localparam logic [ADDR_W-1:0] A_IRQEN = ADDR_W'(OFF_IRQEN);
    localparam logic [ADDR_W-1:0] A_GAIN  = ADDR_W'(OFF_GAIN);
    localparam logic [ADDR_W-1:0] A_PORT  = ADDR_W'(OFF_PORT);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFF_CTRL);

    logic              wren;
    logic              irq_stat;
    logic              irq_en;
    logic              ctrl_wr, port_wr;
    logic              arm, disarm;
    logic              ram_we, load_done, done_set;
    logic [IDX_W-1:0]  ld_ptr;

    assign ctrl_wr = bus_we && (bus_addr == A_CTRL);
    assign port_wr = bus_we && (bus_addr == A_PORT);
    assign arm     = ctrl_wr &&  bus_wdata[CTRL_WREN_BIT] && !wren;
    assign disarm  = ctrl_wr && !bus_wdata[CTRL_WREN_BIT] &&  wren;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            auto_idle_o <= 1'b1;
            irq_stat    <= 1'b0;
            irq_en      <= 1'b0;
            gain0_o     <= '0;
            gain1_o     <= '0;
            st_en_o     <= 1'b0;
            wren        <= 1'b0;
        end else begin
            if (bus_we && bus_addr == A_CFG)   auto_idle_o <= bus_wdata[0];
            if (bus_we && bus_addr == A_IRQEN) irq_en      <= bus_wdata[0];
            if (bus_we && bus_addr == A_GAIN) begin
                gain0_o <= bus_wdata[COEF_W-1:0];
                gain1_o <= bus_wdata[2*COEF_W-1:COEF_W];
            end
            if (ctrl_wr) begin
                st_en_o <= bus_wdata[CTRL_EN_BIT];
                wren    <= bus_wdata[CTRL_WREN_BIT];
            end
            if (done_set)
                irq_stat <= 1'b1;
            else if (bus_we && bus_addr == A_IRQST && bus_wdata[0])
                irq_stat <= 1'b0;
        end
    end

    assign irq_o = irq_stat && irq_en;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_REV:   bus_rdata = DATA_W'(REV_ID);
            A_CFG:   bus_rdata[0] = auto_idle_o;
            A_IRQST: bus_rdata[0] = irq_stat;
            A_IRQEN: bus_rdata[0] = irq_en;
            A_GAIN:  bus_rdata[2*COEF_W-1:0] = {gain1_o, gain0_o};
            A_CTRL: begin
                bus_rdata[CTRL_EN_BIT]   = st_en_o;
                bus_rdata[CTRL_WREN_BIT] = wren;
                bus_rdata[CTRL_DONE_BIT] = load_done;
            end
            default: bus_rdata = '0;
        endcase
    end

    st_load_fsm #(.NTAPS(NTAPS), .IDX_W(IDX_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (arm),
        .disarm   (disarm),
        .port_wr  (port_wr),
        .ram_we   (ram_we),
        .ptr      (ld_ptr),
        .done     (load_done),
        .done_set (done_set)
    );

    st_coef_ram #(.NTAPS(NTAPS), .COEF_W(COEF_W), .IDX_W(IDX_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ld_ptr),
        .wdata (bus_wdata[COEF_W-1:0]),
        .raddr (tap_idx_i),
        .rdata (tap_coef_o)
    );
endmodule

// File: rtl/st_coef_regif_chk.sv
module st_coef_regif_chk #(
    parameter int ADDR_W = 8,
    parameter int COEF_W = 16,
    parameter int IDX_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [COEF_W-1:0] gain0_o,
    input logic [COEF_W-1:0] gain1_o,
    input logic              st_en_o,
    input logic              load_done,
    input logic              irq_stat,
    input logic [IDX_W-1:0]  ld_ptr
);
    logic wr_ctrl, wr_gain, wr_port;
    assign wr_ctrl = bus_we && (bus_addr == ADDR_W'('h2C));
    assign wr_gain = bus_we && (bus_addr == ADDR_W'('h24));
    assign wr_port = bus_we && (bus_addr == ADDR_W'('h28));

    // R3
    gain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_gain |=> ($stable(gain0_o) && $stable(gain1_o)));

    // R4
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(st_en_o));

    // R7
    done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_done) |-> $past(wr_port));

    // R9
    done_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(load_done) |-> $past(wr_ctrl));

    // R8
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_port || wr_ctrl) |=> $stable(ld_ptr));

    // R10
    irq_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_done) |-> irq_stat);
endmodule

bind st_coef_regif st_coef_regif_chk #(
    .ADDR_W(ADDR_W), .COEF_W(COEF_W), .IDX_W(IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .gain0_o   (gain0_o),
    .gain1_o   (gain1_o),
    .st_en_o   (st_en_o),
    .load_done (load_done),
    .irq_stat  (irq_stat),
    .ld_ptr    (ld_ptr)
);

// File: tb/tb_st_coef_regif.sv
module tb_st_coef_regif;
    localparam int CLK_P = 10;
    localparam logic [31:0] REV = 32'h0000_0103;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [6:0]  tap_idx_i = '0;
    logic [15:0] tap_coef_o, gain0_o, gain1_o;
    logic        st_en_o, auto_idle_o, irq_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #(CLK_P/2) clk = ~clk;

    st_coef_regif #(.REV_ID(REV)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tap_idx_i(tap_idx_i),
        .tap_coef_o(tap_coef_o), .gain0_o(gain0_o), .gain1_o(gain1_o),
        .st_en_o(st_en_o), .auto_idle_o(auto_idle_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic tap_chk(input string req, input int idx, input logic [15:0] exp);
        tap_idx_i = 7'(idx);
        #1;
        chk(req, {16'h0, tap_coef_o}, {16'h0, exp});
    endtask

    function automatic logic [15:0] pat(input int base, input int i);
        return 16'(base + i * 37);
    endfunction

    task automatic t_reset();
        rd_chk("R1 cfg", 8'h10, 32'h1);
        rd_chk("R1 ctrl", 8'h2C, 32'h0);
        rd_chk("R1 gain", 8'h24, 32'h0);
        rd_chk("R1 irqst", 8'h18, 32'h0);
        chk("R1 outs", {28'h0, st_en_o, auto_idle_o, irq_o, 1'b0}, 32'h4);
    endtask

    task automatic t_rev();
        rd_chk("R2 rev", 8'h00, REV);
        wr(8'h00, 32'hFFFF_FFFF);
        rd_chk("R2 rev after write", 8'h00, REV);
        rd_chk("R2 unmapped 04", 8'h04, 32'h0);
        rd_chk("R2 unmapped 30", 8'h30, 32'h0);
        rd_chk("R2 port read", 8'h28, 32'h0);
    endtask

    task automatic t_gain();
        wr(8'h24, 32'h8001_7FFF);
        rd_chk("R3 gain rb", 8'h24, 32'h8001_7FFF);
        chk("R3 gain0", {16'h0, gain0_o}, 32'h7FFF);
        chk("R3 gain1", {16'h0, gain1_o}, 32'h8001);
    endtask

    task automatic t_ctrl_cfg();
        wr(8'h2C, 32'h5);
        rd_chk("R4 done ro", 8'h2C, 32'h1);
        chk("R4 st_en", {31'h0, st_en_o}, 32'h1);
        wr(8'h10, 32'h0);
        rd_chk("R5 cfg", 8'h10, 32'h0);
        chk("R5 auto_idle", {31'h0, auto_idle_o}, 32'h0);
    endtask

    task automatic load_n(input int base, input int n);
        for (int i = 0; i < n; i++) wr(8'h28, {16'hABCD, pat(base, i)});
    endtask

    task automatic t_load();
        wr(8'h2C, 32'h3);
        load_n(100, 127);
        rd_chk("R7 not done at 127", 8'h2C, 32'h3);
        load_n(100 + 127 * 37, 1);
        rd_chk("R7 done at 128", 8'h2C, 32'h7);
        tap_chk("R6 tap0", 0, pat(100, 0));
        tap_chk("R6 tap1", 1, pat(100, 1));
        tap_chk("R11 tap64", 64, pat(100, 64));
        tap_chk("R6 tap127", 127, pat(100, 127));
        rd_chk("R10 irqst set", 8'h18, 32'h1);
        chk("R10 irq masked", {31'h0, irq_o}, 32'h0);
        wr(8'h1C, 32'h1);
        chk("R10 irq on", {31'h0, irq_o}, 32'h1);
        wr(8'h18, 32'h1);
        chk("R10 irq cleared", {31'h0, irq_o}, 32'h0);
    endtask

    task automatic t_ignore();
        wr(8'h28, 32'h0000_1234);
        tap_chk("R8 full tap0", 0, pat(100, 0));
        tap_chk("R8 full tap127", 127, pat(100, 127));
        wr(8'h2C, 32'h1);
        rd_chk("R9 done kept", 8'h2C, 32'h5);
        wr(8'h28, 32'h0000_5678);
        tap_chk("R8 disarmed tap0", 0, pat(100, 0));
        tap_chk("R8 disarmed tap127", 127, pat(100, 127));
    endtask

    task automatic t_restart();
        wr(8'h2C, 32'h3);
        rd_chk("R6 arm clears done", 8'h2C, 32'h3);
        load_n(7, 5);
        wr(8'h2C, 32'h1);
        wr(8'h2C, 32'h3);
        wr(8'h28, {16'h0, 16'hBEEF});
        tap_chk("R9 restart tap0", 0, 16'hBEEF);
        tap_chk("R9 restart tap1 old", 1, pat(7, 1));
        load_n(9, 127);
        rd_chk("R9 done after reload", 8'h2C, 32'h7);
        tap_chk("R9 reload tap127", 127, pat(9, 126));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_rev();
        t_gain();
        t_ctrl_cfg();
        t_load();
        t_ignore();
        t_restart();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule